// File: doc/BRIEF.md
# Serial Burst DMA Controller

This block copies fixed-size byte bursts between a large main memory and a small peripheral-side RAM. Software programs it through a 32-bit register port. A write to the main-memory address register sets the base address on that side. A write to one of two start registers loads the peripheral address, fixes the copy direction and arms the transfer. The block does not copy at once. It holds a busy flag for a fixed number of clock cycles and then runs the burst.

When data flows from the peripheral toward memory, the block first sends a one-cycle request that asks the peripheral to process its command buffer. It then waits for a completion strobe and only after that reads any peripheral byte. At the end of every burst an interrupt flag is set. The flag stays set until software writes the status register. Both data ports are byte wide and use synchronous RAM timing, so read data returns one cycle after the strobe.

Top module: `sdma_ctrl`

## Requirements
- R1: A write to offset 0x00 stores the data ANDed with 2^MEM_AW-1 (0x7FFFFF by default) as the memory base. A read of 0x00 returns that value. Read data appears on reg_rdata in the cycle after the read access.
- R2: A start write stores the data ANDed with 2^PER_AW-1 (0x1FFFFFFF by default) as the peripheral base. Reads of offset 0x04 and offset 0x10 both return that value. A read of offset 0x0C returns zero.
- R3: A write to offset 0x04 selects peripheral-to-memory. A write to offset 0x10 selects memory-to-peripheral, and that direction never raises cmd_req.
- R4: The status register at offset 0x18 reads busy in bit 0 and the interrupt flag in bit 12. All other bits read zero.
- R5: After the clock edge that accepts a start, busy is 1 for exactly DELAY cycles. During that time there is no data strobe and no cmd_req. In memory-to-peripheral mode, the first source read strobe appears DELAY+1 cycles after the accepting edge.
- R6: In peripheral-to-memory mode, cmd_req is a single-cycle pulse that appears DELAY cycles after the accepting edge. No byte strobe occurs until cmd_done has been sampled high. The first peripheral read strobe appears in the cycle after that sample.
- R7: A burst moves exactly BURST (64) bytes. Source and destination addresses both increment from their bases and wrap within their widths. Each byte is written one cycle after its read.
- R8: irq rises two cycles after the cycle of the last destination write. Any write to offset 0x18, whatever the data, clears irq. If a set and a clear fall on the same edge, the set wins.
- R9: A read of any offset other than 0x00, 0x04, 0x0C, 0x10 or 0x18 returns zero and sets err. A write to any offset other than 0x00, 0x04, 0x10 or 0x18 changes no register and sets err. err stays set until reset.
- R10: A start write that arrives while a transfer is active is ignored, and the peripheral base and direction are kept. A transfer counts as active from the accepting edge until its last byte is written.
- R11: After reset, every register reads zero and irq, err, cmd_req and all strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_sel | input | 1 | Register access strobe |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | OFS_W | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after a read |
| err | output | 1 | Sticky unmapped-access flag |
| mem_en | output | 1 | Main-memory byte strobe |
| mem_we | output | 1 | Main-memory write enable |
| mem_addr | output | MEM_AW | Main-memory byte address |
| mem_wdata | output | 8 | Main-memory write byte |
| mem_rdata | input | 8 | Main-memory read byte, one cycle after strobe |
| per_en | output | 1 | Peripheral RAM byte strobe |
| per_we | output | 1 | Peripheral RAM write enable |
| per_addr | output | PER_AW | Peripheral RAM byte address |
| per_wdata | output | 8 | Peripheral RAM write byte |
| per_rdata | input | 8 | Peripheral RAM read byte, one cycle after strobe |
| cmd_req | output | 1 | One-cycle command-processing request |
| cmd_done | input | 1 | Command processing finished |
| irq | output | 1 | Transfer-complete interrupt flag |

## Verification
Every result has a fixed cycle count from its stimulus. The bench drives on falling edges and samples on falling edges. For each register access it reads reg_rdata on the falling edge just after the accepting clock edge.

After a start it looks at the strobes and cmd_req on each of the next DELAY falling edges. It expects the first strobe exactly one cycle after the delay expires, or one cycle after cmd_done is sampled. From that first strobe it counts falling edges and requires irq on the 66th, with exactly 64 destination writes before it. Destination contents are compared with patterns that the bench computes from its own fill formulas, including the effect of the command-processing step in peripheral-to-memory bursts.

// File: rtl/sdma_pkg.sv
package sdma_pkg;

  localparam int unsigned OFS_MBASE = 'h00;
  localparam int unsigned OFS_GO_IN = 'h04;
  localparam int unsigned OFS_ZERO  = 'h0C;
  localparam int unsigned OFS_GO_OUT = 'h10;
  localparam int unsigned OFS_STAT  = 'h18;

  localparam int unsigned STAT_BUSY_BIT = 0;
  localparam int unsigned STAT_IRQ_BIT  = 12;

  typedef enum logic [1:0] {
    SEQ_IDLE,
    SEQ_WAIT,
    SEQ_CMD
  } seq_state_e;

endpackage

// File: rtl/sdma_regs.sv
module sdma_regs
  import sdma_pkg::*;
#(
  parameter int OFS_W  = 5,
  parameter int MEM_AW = 23,
  parameter int PER_AW = 29
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_sel,
  input  logic              reg_we,
  input  logic [OFS_W-1:0]  reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              err,
  input  logic              active,
  input  logic              busy,
  input  logic              done_p,
  output logic              start_p,
  output logic              to_mem,
  output logic [MEM_AW-1:0] mem_base,
  output logic [PER_AW-1:0] per_base,
  output logic              irq
);

  localparam logic [31:0] MEM_MASK = 32'((64'd1 << MEM_AW) - 64'd1);
  localparam logic [31:0] PER_MASK = 32'((64'd1 << PER_AW) - 64'd1);

  logic is_mb, is_gi, is_z, is_go, is_st;
  logic wr, rd, rd_ok, wr_ok, start_hit;
  logic [31:0] stat_w;

  always_comb begin
    is_mb = (reg_addr == OFS_W'(OFS_MBASE));
    is_gi = (reg_addr == OFS_W'(OFS_GO_IN));
    is_z  = (reg_addr == OFS_W'(OFS_ZERO));
    is_go = (reg_addr == OFS_W'(OFS_GO_OUT));
    is_st = (reg_addr == OFS_W'(OFS_STAT));
    wr    = reg_sel & reg_we;
    rd    = reg_sel & ~reg_we;
    rd_ok = is_mb | is_gi | is_z | is_go | is_st;
    wr_ok = is_mb | is_gi | is_go | is_st;
    start_hit = wr & (is_gi | is_go);
    start_p   = start_hit & ~active;
    stat_w = (32'(busy) << STAT_BUSY_BIT) | (32'(irq) << STAT_IRQ_BIT);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_base  <= '0;
      per_base  <= '0;
      to_mem    <= 1'b0;
      irq       <= 1'b0;
      err       <= 1'b0;
      reg_rdata <= '0;
    end else begin
      if (wr && is_mb)
        mem_base <= MEM_AW'(reg_wdata & MEM_MASK);
      if (start_p) begin
        per_base <= PER_AW'(reg_wdata & PER_MASK);
        to_mem   <= is_gi;
      end
      if (done_p)
        irq <= 1'b1;
      else if (wr && is_st)
        irq <= 1'b0;
      if ((wr && !wr_ok) || (rd && !rd_ok))
        err <= 1'b1;
      if (rd) begin
        if (is_mb)
          reg_rdata <= 32'(mem_base);
        else if (is_gi || is_go)
          reg_rdata <= 32'(per_base);
        else if (is_st)
          reg_rdata <= stat_w;
        else
          reg_rdata <= '0;
      end
    end
  end

  // R9: error flag never drops outside reset
  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    err |=> err);

  // R10: start while active keeps base and direction
  assert_start_ignored_R10: assert property (@(posedge clk) disable iff (rst)
    (start_hit && active) |=> ($stable(per_base) && $stable(to_mem)));

  // R8: status write without a coincident completion clears the flag
  assert_irq_clear_R8: assert property (@(posedge clk) disable iff (rst)
    (wr && is_st && !done_p) |=> !irq);

endmodule

// File: rtl/sdma_seq.sv
module sdma_seq
  import sdma_pkg::*;
#(
  parameter int DELAY = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic start_p,
  input  logic to_mem,
  input  logic cmd_done,
  output logic busy,
  output logic cmd_req,
  output logic go_p,
  output logic seq_active
);

  localparam int CNT_W = (DELAY > 1) ? $clog2(DELAY) : 1;

  seq_state_e        st;
  logic [CNT_W-1:0]  cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= SEQ_IDLE;
      cnt     <= '0;
      busy    <= 1'b0;
      cmd_req <= 1'b0;
      go_p    <= 1'b0;
    end else begin
      cmd_req <= 1'b0;
      go_p    <= 1'b0;
      unique case (st)
        SEQ_IDLE: begin
          if (start_p) begin
            st   <= SEQ_WAIT;
            cnt  <= CNT_W'(DELAY - 1);
            busy <= 1'b1;
          end
        end
        SEQ_WAIT: begin
          if (cnt == '0) begin
            busy <= 1'b0;
            if (to_mem) begin
              st      <= SEQ_CMD;
              cmd_req <= 1'b1;
            end else begin
              st   <= SEQ_IDLE;
              go_p <= 1'b1;
            end
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end
        SEQ_CMD: begin
          if (cmd_done && !cmd_req) begin
            st   <= SEQ_IDLE;
            go_p <= 1'b1;
          end
        end
        default: st <= SEQ_IDLE;
      endcase
    end
  end

  assign seq_active = (st != SEQ_IDLE) | go_p;

  // R6: the command request lasts one cycle
  assert_cmd_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    cmd_req |=> !cmd_req);

  // R5: busy drops only when the burst or the handshake is launched
  assert_busy_end_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (go_p || cmd_req));

endmodule

// File: rtl/sdma_mover.sv
module sdma_mover #(
  parameter int MEM_AW = 23,
  parameter int PER_AW = 29,
  parameter int BURST  = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go_p,
  input  logic              to_mem,
  input  logic [MEM_AW-1:0] mem_base,
  input  logic [PER_AW-1:0] per_base,
  output logic              run,
  output logic              done_p,
  output logic              mem_en,
  output logic              mem_we,
  output logic [MEM_AW-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata,
  output logic              per_en,
  output logic              per_we,
  output logic [PER_AW-1:0] per_addr,
  output logic [7:0]        per_wdata,
  input  logic [7:0]        per_rdata
);

  localparam int NW = $clog2(BURST) + 1;

  logic [NW-1:0]     n, n_prev;
  logic              dir_q;
  logic [MEM_AW-1:0] mb_q;
  logic [PER_AW-1:0] pb_q;
  logic              rd_en, wr_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      run    <= 1'b0;
      done_p <= 1'b0;
      n      <= '0;
      dir_q  <= 1'b0;
      mb_q   <= '0;
      pb_q   <= '0;
    end else begin
      done_p <= 1'b0;
      if (!run) begin
        if (go_p) begin
          run   <= 1'b1;
          n     <= '0;
          dir_q <= to_mem;
          mb_q  <= mem_base;
          pb_q  <= per_base;
        end
      end else if (n == NW'(BURST)) begin
        run    <= 1'b0;
        done_p <= 1'b1;
      end else begin
        n <= n + NW'(1);
      end
    end
  end

  always_comb begin
    n_prev = n - NW'(1);
    rd_en  = run && (n < NW'(BURST));
    wr_en  = run && (n != '0);
    mem_wdata = per_rdata;
    per_wdata = mem_rdata;
    if (dir_q) begin
      per_en   = rd_en;
      per_we   = 1'b0;
      per_addr = pb_q + PER_AW'(n);
      mem_en   = wr_en;
      mem_we   = wr_en;
      mem_addr = mb_q + MEM_AW'(n_prev);
    end else begin
      mem_en   = rd_en;
      mem_we   = 1'b0;
      mem_addr = mb_q + MEM_AW'(n);
      per_en   = wr_en;
      per_we   = wr_en;
      per_addr = pb_q + PER_AW'(n_prev);
    end
  end

  // R7: completion follows the last write step of a full burst
  assert_done_after_last_R7: assert property (@(posedge clk) disable iff (rst)
    done_p |-> $past(run && (n == NW'(BURST))));

  // R7: one side is written per cycle at most
  assert_one_writer_R7: assert property (@(posedge clk) disable iff (rst)
    !(mem_we && per_we));

endmodule

// File: rtl/sdma_ctrl.sv
module sdma_ctrl #(
  parameter int OFS_W  = 5,
  parameter int MEM_AW = 23,
  parameter int PER_AW = 29,
  parameter int BURST  = 64,
  parameter int DELAY  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_sel,
  input  logic              reg_we,
  input  logic [OFS_W-1:0]  reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              err,
  output logic              mem_en,
  output logic              mem_we,
  output logic [MEM_AW-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata,
  output logic              per_en,
  output logic              per_we,
  output logic [PER_AW-1:0] per_addr,
  output logic [7:0]        per_wdata,
  input  logic [7:0]        per_rdata,
  output logic              cmd_req,
  input  logic              cmd_done,
  output logic              irq
);

  logic start_p, to_mem, busy, go_p, seq_active, run, done_p, active;
  logic [MEM_AW-1:0] mem_base;
  logic [PER_AW-1:0] per_base;

  assign active = seq_active | run;

  sdma_regs #(.OFS_W(OFS_W), .MEM_AW(MEM_AW), .PER_AW(PER_AW)) regs_i (
    .clk(clk), .rst(rst),
    .reg_sel(reg_sel), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .err(err),
    .active(active), .busy(busy), .done_p(done_p),
    .start_p(start_p), .to_mem(to_mem),
    .mem_base(mem_base), .per_base(per_base), .irq(irq)
  );

  sdma_seq #(.DELAY(DELAY)) seq_i (
    .clk(clk), .rst(rst),
    .start_p(start_p), .to_mem(to_mem), .cmd_done(cmd_done),
    .busy(busy), .cmd_req(cmd_req), .go_p(go_p), .seq_active(seq_active)
  );

  sdma_mover #(.MEM_AW(MEM_AW), .PER_AW(PER_AW), .BURST(BURST)) mover_i (
    .clk(clk), .rst(rst),
    .go_p(go_p), .to_mem(to_mem), .mem_base(mem_base), .per_base(per_base),
    .run(run), .done_p(done_p),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .per_en(per_en), .per_we(per_we), .per_addr(per_addr),
    .per_wdata(per_wdata), .per_rdata(per_rdata)
  );

endmodule

// File: tb/sdma_ctrl_tb.sv
module sdma_ctrl_tb_top;

  localparam int DLY = 16;
  localparam int CMD_LAT = 5;

  // {to_mem, mem address, peripheral address}
  localparam logic [64:0] VECS [0:3] = '{
    {1'b0, 32'h0000_0010, 32'h1FC0_07C0},
    {1'b1, 32'h0000_0100, 32'h1FC0_07C0},
    {1'b1, 32'hFFFF_FFE0, 32'hFFFF_FFF0},
    {1'b0, 32'h0080_0040, 32'h0000_0020}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_sel = 1'b0, reg_we = 1'b0;
  logic [4:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic err, mem_en, mem_we, per_en, per_we, cmd_req, irq;
  logic cmd_done = 1'b0;
  logic [22:0] mem_addr;
  logic [28:0] per_addr;
  logic [7:0] mem_wdata, per_wdata;
  logic [7:0] mem_rd = '0, per_rd = '0;
  logic [7:0] mem_ram [0:255];
  logic [7:0] per_ram [0:255];
  logic fill_req = 1'b0, proc_req = 1'b0;
  int fill_tag = 0;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  sdma_ctrl #(.DELAY(DLY)) dut_i (
    .clk(clk), .rst(rst),
    .reg_sel(reg_sel), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .err(err),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rd),
    .per_en(per_en), .per_we(per_we), .per_addr(per_addr),
    .per_wdata(per_wdata), .per_rdata(per_rd),
    .cmd_req(cmd_req), .cmd_done(cmd_done), .irq(irq)
  );

  // memory models, pattern fill and command processing share one writer
  always @(posedge clk) begin
    if (fill_req) begin
      for (int i = 0; i < 256; i++) begin
        mem_ram[i] <= 8'(i * 3 + fill_tag);
        per_ram[i] <= 8'(i * 7 + fill_tag * 11 + 1);
      end
    end else if (proc_req) begin
      for (int i = 0; i < 256; i++) per_ram[i] <= per_ram[i] ^ 8'hA5;
    end else begin
      if (mem_en) begin
        if (mem_we) mem_ram[mem_addr[7:0]] <= mem_wdata;
        mem_rd <= mem_ram[mem_addr[7:0]];
      end
      if (per_en) begin
        if (per_we) per_ram[per_addr[7:0]] <= per_wdata;
        per_rd <= per_ram[per_addr[7:0]];
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [4:0] a, input logic [31:0] d);
    reg_sel = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_sel = 1'b0; reg_we = 1'b0;
  endtask

  task automatic reg_rd(input logic [4:0] a, output logic [31:0] d);
    reg_sel = 1'b1; reg_we = 1'b0; reg_addr = a;
    @(negedge clk);
    reg_sel = 1'b0;
    d = reg_rdata;
  endtask

  task automatic fill(input int tag);
    fill_tag = tag; fill_req = 1'b1;
    @(negedge clk);
    fill_req = 1'b0;
  endtask

  task automatic wait_irq(output int t, output int writes, input bit to_mem);
    t = 0; writes = 0;
    while (!irq && t < 300) begin
      if (to_mem ? mem_we : per_we) writes++;
      @(negedge clk);
      t++;
    end
  endtask

  task automatic run_vec(input int v);
    logic to_mem;
    logic [31:0] ma, pa, d;
    int viol, t, writes, bad;
    to_mem = VECS[v][64];
    ma = VECS[v][63:32];
    pa = VECS[v][31:0];
    fill(v);
    reg_wr(5'h00, ma);
    reg_wr(to_mem ? 5'h04 : 5'h10, pa);
    viol = 0;
    for (int j = 0; j < DLY; j++) begin
      if (mem_en || per_en || cmd_req) viol++;
      @(negedge clk);
    end
    chk(viol == 0, "R5", "activity during delay", 32'(viol), 0);
    if (to_mem) begin
      chk(cmd_req == 1'b1, "R6", "cmd_req after delay", 32'(cmd_req), 1);
      @(negedge clk);
      chk(cmd_req == 1'b0, "R6", "cmd_req width", 32'(cmd_req), 0);
      viol = 0;
      for (int k = 0; k < CMD_LAT; k++) begin
        if (mem_en || per_en) viol++;
        @(negedge clk);
      end
      proc_req = 1'b1;
      @(negedge clk);
      proc_req = 1'b0;
      cmd_done = 1'b1;
      @(negedge clk);
      cmd_done = 1'b0;
      if (mem_en || per_en) viol++;
      chk(viol == 0, "R6", "strobe before done", 32'(viol), 0);
      @(negedge clk);
      chk(per_en && !per_we && !mem_en, "R6", "first peripheral read",
          {29'b0, per_en, per_we, mem_en}, 32'h4);
    end else begin
      chk(!mem_en && !per_en && !cmd_req, "R3", "no strobe or request at expiry",
          {29'b0, mem_en, per_en, cmd_req}, 0);
      @(negedge clk);
      chk(mem_en && !mem_we && !per_en, "R5", "first memory read",
          {29'b0, mem_en, mem_we, per_en}, 32'h4);
    end
    wait_irq(t, writes, to_mem);
    chk(t == 66, "R8", "cycles from first strobe to irq", 32'(t), 66);
    chk(writes == 64, "R7", "destination writes", 32'(writes), 64);
    bad = 0;
    for (int i = 0; i < 64; i++) begin
      logic [7:0] mi, pi, exp_b, act_b;
      mi = 8'(ma) + 8'(i);
      pi = 8'(pa) + 8'(i);
      if (to_mem) begin
        exp_b = 8'(pi * 7 + v * 11 + 1) ^ 8'hA5;
        act_b = mem_ram[mi];
      end else begin
        exp_b = 8'(mi * 3 + v);
        act_b = per_ram[pi];
      end
      if (act_b !== exp_b) bad++;
    end
    chk(bad == 0, "R7", "burst contents", 32'(bad), 0);
    reg_rd(5'h00, d);
    chk(d == (ma & 32'h007F_FFFF), "R1", "memory base readback", d, ma & 32'h007F_FFFF);
    reg_rd(5'h04, d);
    chk(d == (pa & 32'h1FFF_FFFF), "R2", "peripheral base at 0x04", d, pa & 32'h1FFF_FFFF);
    reg_rd(5'h10, d);
    chk(d == (pa & 32'h1FFF_FFFF), "R2", "peripheral base at 0x10", d, pa & 32'h1FFF_FFFF);
    reg_rd(5'h18, d);
    chk(d == 32'h0000_1000, "R4", "status after burst", d, 32'h0000_1000);
    reg_wr(5'h18, 32'hDEAD_BEEF ^ 32'(v));
    chk(irq == 1'b0, "R8", "irq after status write", 32'(irq), 0);
    reg_rd(5'h18, d);
    chk(d == 32'h0, "R4", "status after clear", d, 0);
  endtask

  initial begin
    logic [31:0] d;
    int t, writes, seen, bad;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R11 reset state
    chk(!irq && !err && !cmd_req && !mem_en && !per_en, "R11", "outputs after reset",
        {27'b0, irq, err, cmd_req, mem_en, per_en}, 0);
    reg_rd(5'h00, d);
    chk(d == 0, "R11", "memory base after reset", d, 0);
    reg_rd(5'h04, d);
    chk(d == 0, "R11", "peripheral base after reset", d, 0);
    reg_rd(5'h18, d);
    chk(d == 0, "R11", "status after reset", d, 0);
    reg_rd(5'h0C, d);
    chk(d == 0 && !err, "R2", "offset 0x0C reads zero", d, 0);

    for (int v = 0; v < 4; v++) run_vec(v);

    // R10: a second start during the delay is dropped
    fill(9);
    reg_wr(5'h00, 32'h20);
    reg_wr(5'h10, 32'h40);
    reg_rd(5'h18, d);
    chk(d == 32'h1, "R5", "busy bit during delay", d, 32'h1);
    reg_wr(5'h04, 32'h80);
    reg_rd(5'h04, d);
    chk(d == 32'h40, "R10", "base kept on ignored start", d, 32'h40);
    seen = 0; t = 0;
    while (!irq && t < 300) begin
      if (cmd_req) seen++;
      @(negedge clk);
      t++;
    end
    chk(seen == 0 && irq, "R10", "direction kept, no request", 32'(seen), 0);
    bad = 0;
    for (int i = 0; i < 64; i++)
      if (per_ram[8'h40 + 8'(i)] !== 8'((8'h20 + i) * 3 + 9)) bad++;
    chk(bad == 0, "R10", "original burst contents", 32'(bad), 0);
    reg_wr(5'h18, 32'h0);
    chk(irq == 1'b0, "R8", "clear with zero data", 32'(irq), 0);

    // R9: unmapped accesses
    chk(err == 1'b0, "R9", "err before fault", 32'(err), 0);
    reg_rd(5'h08, d);
    chk(d == 0 && err, "R9", "unmapped read", d, 0);
    reg_wr(5'h0C, 32'h123);
    reg_rd(5'h18, d);
    chk(d == 0, "R9", "write to 0x0C starts nothing", d, 0);
    reg_wr(5'h1C, 32'hFFFF_FFFF);
    reg_rd(5'h00, d);
    chk(d == 32'h20, "R9", "unmapped write leaves base", d, 32'h20);
    repeat (3) @(negedge clk);
    chk(err == 1'b1, "R9", "err sticky", 32'(err), 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule